// File: doc/BRIEF.md
# Staggered Pad Tower Coincidence

This block decides which trigger towers fired in one bunch crossing from the pad hits of two four-layer wedges: a pivot wedge and a confirm wedge. Pad hits arrive as 32-bit words, one per group of 32 pads of one layer of one wedge. Each word carries its wedge, layer and group address. The final word of a crossing is flagged. The block ORs every word into its per-layer pad vectors. It then evaluates all towers at once and streams out the fired towers. Each output beat carries the tower index, the strip band that the centroid logic should receive, and the bunch-crossing number.

The layers are staggered by one pad. Tower `t` therefore takes pad `t+L` from layer `L` of each wedge, and a wedge agrees with the tower when at least three of its four taps are hit. A tower fires only when both wedges agree. The crossing number comes from a 12-bit count of closed crossings, which a bunch-counter-reset pulse sets back to zero.

Both data interfaces use valid/ready. A word or output beat moves on a clock edge where both valid and ready are high. The input side accepts one crossing at a time. `in_ready` falls in the cycle after the closing word and stays low until the last tower of that crossing has been taken. While `out_ready` is low, the current output beat holds all of its fields.

Top module: `pad_tower_trig`

## Requirements
- R1: A wedge agrees with tower `t` when at least 3 of its 4 taps are hit. The taps are pad `t+L` of layer `L`, for L = 0..3. Two hits are not enough.
- R2: A tower fires only when the pivot wedge (`in_wedge`=0) and the confirm wedge (`in_wedge`=1) both agree with it.
- R3: Only the staggered pad `t+L` counts for layer `L`; pads `t+L-1` and `t+L+1` do not. A tap past the last pad counts as not hit, so the top towers can still fire on their lower three layers.
- R4: Bit `i` of a word with group `g` is pad `g*32+i` of the addressed wedge and layer. Words of a crossing may arrive in any order, and a tower may use pads from two groups.
- R5: The fired towers of a crossing leave in ascending index order, one per accepted beat. `out_last` is high on the final one. A crossing with no fired tower produces no beat.
- R6: `out_band` comes from a table indexed by tower number. By default it is the tower index divided by 4 (integer division).
- R7: Every beat of a crossing carries the same `out_bcid`, equal to the number of crossings closed since the last `bcr` pulse, modulo 4096. If `bcr` is high in the same cycle as the closing word, that crossing is tagged 0 and the next one is tagged 1.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` and all output fields hold. `in_ready` is low from the cycle after the closing word until the final beat is accepted.
- R9: Pad hits from one crossing never count toward a later crossing.
- R10: After reset, `in_ready` is 1, `out_valid` is 0, and the crossing count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bcr | input | 1 | Bunch-counter reset pulse |
| in_valid | input | 1 | Pad word valid |
| in_ready | output | 1 | Block can take a pad word |
| in_last | input | 1 | Word closes the crossing |
| in_wedge | input | 1 | 0 = pivot wedge, 1 = confirm wedge |
| in_layer | input | 2 | Layer within the wedge |
| in_group | input | GRP_W (1) | Group of 32 pads within the layer |
| in_data | input | 32 | Hit bits of the 32 pads of the group |
| out_valid | output | 1 | Fired tower beat valid |
| out_ready | input | 1 | Consumer takes the beat |
| out_last | output | 1 | Final fired tower of the crossing |
| out_tower | output | TW (6) | Tower index |
| out_band | output | BAND_W (4) | Strip band for the centroid logic |
| out_bcid | output | 12 | Crossing number of the tower |

## Verification
The hardest case is a crossing that fires many towers while the consumer stalls at random. This is the only case that exercises the ascending walk, the hold during stalls, and the gating of `in_ready` all at once. The bench drives a crossing with every pad hit, which fires all towers but the top two, and randomly sized pad clouds, then deasserts `out_ready` on about half the cycles. The staggering rules are covered by directed patterns: unshifted pads that never align, the upper edge, and a tower that straddles two groups. A `bcr` pulse lands both between crossings and on a closing word.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int WORD_W = 32;
  localparam int LAYERS = 4;
  localparam int WEDGES = 2;
  localparam int BCID_W = 12;

  // at least three of four taps set
  function automatic logic maj3of4(input logic [3:0] v);
    return (v[0] & v[1] & v[2]) | (v[0] & v[1] & v[3]) |
           (v[0] & v[2] & v[3]) | (v[1] & v[2] & v[3]);
  endfunction
endpackage

// File: rtl/ptc_deser.sv
module ptc_deser
  import ptc_pkg::*;
#(
  parameter int NUM_GROUPS = 2,
  parameter int GRP_W      = 1,
  localparam int NP        = NUM_GROUPS * WORD_W
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  wr_en,
  input  logic                                  wr_wedge,
  input  logic [1:0]                            wr_layer,
  input  logic [GRP_W-1:0]                      wr_group,
  input  logic [WORD_W-1:0]                     wr_data,
  input  logic                                  clear,
  output logic [WEDGES-1:0][LAYERS-1:0][NP-1:0] hits
);
  logic grp_ok;
  assign grp_ok = int'(wr_group) < NUM_GROUPS;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      hits <= '0;
    end else if (wr_en && grp_ok) begin
      hits[wr_wedge][wr_layer][wr_group*WORD_W +: WORD_W] <=
        hits[wr_wedge][wr_layer][wr_group*WORD_W +: WORD_W] | wr_data;
    end
  end

  AST_CROSSING_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (hits == '0)); // R9
endmodule

// File: rtl/ptc_coinc.sv
module ptc_coinc
  import ptc_pkg::*;
#(
  parameter int NP = 64,
  localparam int NT = NP
) (
  input  logic [WEDGES-1:0][LAYERS-1:0][NP-1:0] hits,
  output logic [NT-1:0]                         fire
);
  for (genvar t = 0; t < NT; t++) begin : g_tower
    logic [WEDGES-1:0][LAYERS-1:0] tap;
    for (genvar w = 0; w < WEDGES; w++) begin : g_wedge
      for (genvar l = 0; l < LAYERS; l++) begin : g_layer
        if (t + l < NP) begin : g_in
          assign tap[w][l] = hits[w][l][t+l];
        end else begin : g_edge
          assign tap[w][l] = 1'b0;
        end
      end
    end
    assign fire[t] = maj3of4(tap[0]) & maj3of4(tap[1]);
  end
endmodule

// File: rtl/ptc_report.sv
module ptc_report
  import ptc_pkg::*;
#(
  parameter int NT = 64,
  parameter int TW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close,
  input  logic              bcr,
  input  logic              load,
  input  logic [NT-1:0]     fire,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic [TW-1:0]     out_tower,
  output logic [BCID_W-1:0] out_bcid
);
  logic [NT-1:0]     mask_q, low_bit;
  logic [BCID_W-1:0] cnt_q, tag_now;

  assign tag_now = bcr ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      out_bcid <= '0;
    end else if (close) begin
      cnt_q    <= tag_now + 1'b1;
      out_bcid <= tag_now;
    end else if (bcr) begin
      cnt_q    <= '0;
    end
  end

  assign low_bit = mask_q & (~mask_q + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)                      mask_q <= '0;
    else if (load)                   mask_q <= fire;
    else if (out_valid && out_ready) mask_q <= mask_q & ~low_bit;
  end

  always_comb begin
    out_tower = '0;
    for (int i = NT - 1; i >= 0; i--)
      if (mask_q[i]) out_tower = TW'(i);
  end

  assign out_valid = |mask_q;
  assign out_last  = (mask_q & ~low_bit) == '0;

  AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_tower) && $stable(out_bcid)); // R8
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid && (out_tower > $past(out_tower))); // R5
  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(load)); // R5
  AST_BCR_ON_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    close && bcr |=> out_bcid == '0); // R7
endmodule

// File: rtl/pad_tower_trig.sv
module pad_tower_trig
  import ptc_pkg::*;
#(
  parameter int NUM_GROUPS      = 2,
  parameter int TOWERS_PER_BAND = 4,
  localparam int NP        = NUM_GROUPS * WORD_W,
  localparam int NT        = NP,
  localparam int TW        = $clog2(NT),
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int NUM_BANDS = (NT + TOWERS_PER_BAND - 1) / TOWERS_PER_BAND,
  localparam int BAND_W    = (NUM_BANDS > 1) ? $clog2(NUM_BANDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bcr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_last,
  input  logic              in_wedge,
  input  logic [1:0]        in_layer,
  input  logic [GRP_W-1:0]  in_group,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic [TW-1:0]     out_tower,
  output logic [BAND_W-1:0] out_band,
  output logic [BCID_W-1:0] out_bcid
);
  function automatic logic [NT*BAND_W-1:0] make_band_table();
    logic [NT*BAND_W-1:0] tab;
    tab = '0;
    for (int t = 0; t < NT; t++) tab[t*BAND_W +: BAND_W] = BAND_W'(t / TOWERS_PER_BAND);
    return tab;
  endfunction
  localparam logic [NT*BAND_W-1:0] BAND_TABLE = make_band_table();

  logic accept, close, eval_q;
  logic [WEDGES-1:0][LAYERS-1:0][NP-1:0] hits;
  logic [NT-1:0] fire;

  assign in_ready = !eval_q && !out_valid;
  assign accept   = in_valid && in_ready;
  assign close    = accept && in_last;

  always_ff @(posedge clk) begin
    if (!rst_n) eval_q <= 1'b0;
    else        eval_q <= close;
  end

  ptc_deser #(.NUM_GROUPS(NUM_GROUPS), .GRP_W(GRP_W)) i_deser (
    .clk(clk), .rst_n(rst_n), .wr_en(accept), .wr_wedge(in_wedge),
    .wr_layer(in_layer), .wr_group(in_group), .wr_data(in_data),
    .clear(eval_q), .hits(hits)
  );

  ptc_coinc #(.NP(NP)) i_coinc (.hits(hits), .fire(fire));

  ptc_report #(.NT(NT), .TW(TW)) i_report (
    .clk(clk), .rst_n(rst_n), .close(close), .bcr(bcr), .load(eval_q),
    .fire(fire), .out_ready(out_ready), .out_valid(out_valid),
    .out_last(out_last), .out_tower(out_tower), .out_bcid(out_bcid)
  );

  assign out_band = BAND_TABLE[out_tower*BAND_W +: BAND_W];

  AST_BUSY_AFTER_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    close |=> !in_ready); // R8
endmodule

// File: tb/test_pad_tower_trig.sv
module test_pad_tower_trig;
  localparam int NG = 2, NP = NG * 32, TPB = 4;

  logic clk = 1'b0, rst_n = 1'b0, bcr = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, in_wedge = 1'b0;
  logic [1:0] in_layer = '0;
  logic [0:0] in_group = '0;
  logic [31:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic out_ready = 1'b0;
  logic [5:0] out_tower;
  logic [3:0] out_band;
  logic [11:0] out_bcid;

  pad_tower_trig i_pad_tower_trig (
    .clk(clk), .rst_n(rst_n), .bcr(bcr), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_wedge(in_wedge), .in_layer(in_layer), .in_group(in_group),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .out_tower(out_tower), .out_band(out_band), .out_bcid(out_bcid)
  );

  always #2 clk = ~clk;  // 250 MHz

  int checks = 0, fails = 0, bcid_model = 0, stall_pct = 0;
  bit pads [2][4][NP];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit agrees(int w, int t);
    int n = 0;
    for (int l = 0; l < 4; l++) if (t + l < NP && pads[w][l][t+l]) n++;
    return n >= 3;
  endfunction

  function automatic bit exp_fire(int t);
    return agrees(0, t) && agrees(1, t);
  endfunction

  task automatic clear_pads();
    for (int w = 0; w < 2; w++) for (int l = 0; l < 4; l++) for (int p = 0; p < NP; p++) pads[w][l][p] = 1'b0;
  endtask

  task automatic diag(int w, int t, bit [3:0] lmask);
    for (int l = 0; l < 4; l++) if (lmask[l] && t + l < NP) pads[w][l][t+l] = 1'b1;
  endtask

  task automatic crossing(input string tag, input bit bcr_on_last);
    int total = 8 * NG;
    int off = $urandom % total;
    int expq [$];
    int tagv, got, guard;
    bit stalled;
    logic [5:0] s_tower; logic [11:0] s_bcid;
    for (int k = 0; k < total; k++) begin
      int idx = (k + off) % total;
      int w = idx / (4 * NG), l = (idx / NG) % 4, g = idx % NG;
      @(negedge clk);
      in_valid = 1'b1; in_wedge = w[0]; in_layer = l[1:0]; in_group = g[0];
      for (int i = 0; i < 32; i++) in_data[i] = pads[w][l][g*32+i];
      in_last = (k == total - 1);
      bcr = bcr_on_last && (k == total - 1);
      while (!in_ready) @(negedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0; bcr = 1'b0;
    tagv = bcr_on_last ? 0 : bcid_model;
    bcid_model = (tagv + 1) % 4096;
    for (int t = 0; t < NP; t++) if (exp_fire(t)) expq.push_back(t);
    got = 0; guard = 0; stalled = 1'b0;
    while (guard < 2000) begin
      guard++;
      if (!out_valid && in_ready) break;
      if (out_valid) begin
        chk(!in_ready, "R8", "in_ready while busy", in_ready, 0);
        if (stalled) begin
          chk(out_tower == s_tower, "R8", "tower held", out_tower, s_tower);
          chk(out_bcid == s_bcid, "R8", "bcid held", out_bcid, s_bcid);
        end
        out_ready = ($urandom % 100) >= stall_pct;
        if (out_ready) begin
          int et = (got < expq.size()) ? expq[got] : -1;
          chk(int'(out_tower) == et, tag, "tower", out_tower, et);
          chk(int'(out_band) == (et / TPB), "R6", "band", out_band, et / TPB);
          chk(int'(out_bcid) == tagv, "R7", "bcid", out_bcid, tagv);
          chk(out_last == (got == expq.size() - 1), "R5", "last", out_last, got == expq.size() - 1);
          got++;
          stalled = 1'b0;
        end else begin
          stalled = 1'b1; s_tower = out_tower; s_bcid = out_bcid;
        end
      end
      @(negedge clk);
      out_ready = 1'b0;
    end
    chk(got == expq.size(), tag, "tower count", got, expq.size());
  endtask

  task automatic pulse_bcr();
    @(negedge clk); bcr = 1'b1;
    @(negedge clk); bcr = 1'b0;
    bcid_model = 0;
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R10", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R10", "out_valid after reset", out_valid, 0);

    clear_pads(); diag(0, 5, 4'b0111); diag(1, 5, 4'b1111);
    crossing("R1", 1'b0);
    clear_pads(); diag(0, 5, 4'b0011); diag(1, 5, 4'b1111);
    crossing("R1", 1'b0);
    clear_pads(); diag(0, 9, 4'b1111); diag(1, 9, 4'b1010);
    crossing("R2", 1'b0);
    clear_pads();
    for (int w = 0; w < 2; w++) for (int l = 0; l < 4; l++) pads[w][l][10] = 1'b1;
    crossing("R3", 1'b0);
    clear_pads(); diag(0, NP-3, 4'b0111); diag(1, NP-3, 4'b0111);
    diag(0, NP-1, 4'b1111); diag(1, NP-1, 4'b1111);
    crossing("R3", 1'b0);
    clear_pads(); diag(0, 30, 4'b1111); diag(1, 30, 4'b1101);
    crossing("R4", 1'b0);
    clear_pads();
    crossing("R9", 1'b0);
    pulse_bcr();
    clear_pads(); diag(0, 1, 4'b1111); diag(1, 1, 4'b1111);
    crossing("R7", 1'b0);
    crossing("R7", 1'b1);
    stall_pct = 50;
    for (int w = 0; w < 2; w++) for (int l = 0; l < 4; l++) for (int p = 0; p < NP; p++) pads[w][l][p] = 1'b1;
    crossing("R5", 1'b0);
    for (int n = 0; n < 40; n++) begin
      int dens = 20 + ($urandom % 50);
      stall_pct = $urandom % 70;
      for (int w = 0; w < 2; w++) for (int l = 0; l < 4; l++) for (int p = 0; p < NP; p++)
        pads[w][l][p] = ($urandom % 100) < dens;
      crossing("R1", ($urandom % 8) == 0);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule